// File: doc/BRIEF.md
# Priority-Group Warp Issue Scheduler

This block picks one warp to issue per clock for a single SIMD core. It tracks which warps are ready and which are parked waiting on memory. A register of priority bits marks a group of warps as preferred. Ready members of that group always beat ordinary warps, so a small set of warps keeps its lines in the cache. Within each class the choice rotates round-robin, and each class keeps its own rotation pointer.

Software forms the group with a set command that carries a warp mask. It dissolves the group with a clear command. A lock bit makes the group persistent: further set commands are refused until a clear arrives. If the mask names more warps than the group may hold, only the lowest-numbered ones are kept.

A warp that misses in the cache is reported on the stall input together with the number of memory requests it has outstanding. The warp leaves the ready set and joins a first-in first-out waiting queue. Completion pulses always go to the oldest waiting warp. When that warp has received as many completions as it had requests, it returns to the ready set.

Top module: `warp_prio_sched`

## Requirements
- R1: Each cycle in which at least one warp is ready, exactly one ready warp is granted. The grant is registered: `grant_valid_o`/`grant_warp_o` after clock edge k reflect the ready and priority state held just before edge k. `grant_valid_o` is 0 when no warp was ready.
- R2: With no high-priority warps, grants rotate round-robin over the ready warps. The search starts one index above the previously granted warp of that class and wraps from NUM_WARPS-1 to 0.
- R3: A set command (`prio_set_i`) while unlocked makes the warps in `prio_mask_i` high priority and sets the lock. Bit i of the mask is warp i. If more than MAX_GROUP bits are set, only the MAX_GROUP lowest-numbered set bits are kept.
- R4: While any high-priority warp is ready, only high-priority warps are granted. They rotate round-robin with their own pointer, and the normal-class pointer is left untouched.
- R5: A clear command (`prio_clr_i`) empties the group and releases the lock at the next edge. A clear and a set in the same cycle leave the group empty.
- R6: A set command while the lock is held is ignored; the group membership is unchanged.
- R7: A stall on warp w (`stall_valid_i`, `stall_warp_i`) is accepted only if w is not already waiting and is either ready or being made ready in that same cycle (stall wins over ready). An accepted warp leaves the ready set and enters the tail of the waiting queue. A stall on a warp that is neither ready nor becoming ready is ignored. A ready pulse for a waiting warp is ignored.
- R8: Each `mem_done_i` pulse counts one completion for the oldest waiting warp. That warp returns to the ready set on the edge of its r-th completion, where r is its `stall_reqs_i` value and 0 counts as 1. A pulse with an empty queue is ignored.
- R9: After reset no warp is ready, waiting or high priority, the lock is clear, both pointers are 0 and `grant_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready_i | input | NUM_WARPS | Per-warp pulse adding the warp to the ready set |
| stall_valid_i | input | 1 | A warp missed in cache this cycle |
| stall_warp_i | input | $clog2(NUM_WARPS) | Index of the stalled warp |
| stall_reqs_i | input | REQ_W | Outstanding memory requests of the stalled warp |
| mem_done_i | input | 1 | One memory request of the oldest waiting warp completed |
| prio_set_i | input | 1 | Form a high-priority group |
| prio_mask_i | input | NUM_WARPS | Warps requested for the group |
| prio_clr_i | input | 1 | Dissolve the group and release the lock |
| grant_valid_o | output | 1 | A warp is granted issue this cycle |
| grant_warp_o | output | $clog2(NUM_WARPS) | Index of the granted warp |

## Verification
Every input takes effect on the state at the edge where it is sampled, and the grant that reflects that state appears one edge later. A stalled warp therefore stops being granted two edges after its stall is driven, and a returning warp may be granted on the edge after its final completion. The bench models queues, sets and pointers behaviourally. At each rising edge it computes the expected grant from the model state held before the edge, then updates the model with the inputs sampled at that edge. It compares both grant outputs at the following falling edge, so every comparison lands on the cycle the registered outputs are due.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Issue class of a warp; also indexes the per-class rotation pointers.
  typedef enum logic [0:0] {
    CLS_NORM = 1'b0,
    CLS_HIGH = 1'b1
  } prio_class_e;

  localparam int NUM_CLASSES = 2;

endpackage

// File: rtl/warp_rr_pick.sv
// Round-robin picker: first requesting index at or above ptr, wrapping.
module warp_rr_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    // Descending scan so the smallest offset from ptr is the last assignment.
    for (int i = N - 1; i >= 0; i--) begin
      if (req[(int'(ptr) + i) % N]) begin
        hit = 1'b1;
        idx = IW'((int'(ptr) + i) % N);
      end
    end
  end

endmodule

// File: rtl/warp_prio_group.sv
// High-priority membership bits with a lock that makes the group persistent.
module warp_prio_group #(
  parameter int N         = 8,
  parameter int MAX_GROUP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_i,
  input  logic [N-1:0] mask_i,
  input  logic         clr_i,
  output logic [N-1:0] prio_o
);

  logic [N-1:0] prio_q;
  logic         lock_q;
  logic [N-1:0] kept;

  // Keep only the MAX_GROUP lowest-numbered requested warps.
  always_comb begin
    int taken;
    taken = 0;
    kept  = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && taken < MAX_GROUP) begin
        kept[i] = 1'b1;
        taken   = taken + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      prio_q <= '0;
      lock_q <= 1'b0;
    end else if (set_i && !lock_q) begin
      prio_q <= kept;
      lock_q <= 1'b1;
    end
  end

  assign prio_o = prio_q;

  a_r3_group_limit: assert property (@(posedge clk) disable iff (rst)
    $countones(prio_q) <= MAX_GROUP);

  a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (lock_q && set_i && !clr_i) |=> $stable(prio_q));

  a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (prio_q == '0 && !lock_q));

endmodule

// File: rtl/warp_wait_fifo.sv
// FIFO of waiting warps. Completions are credited to the head entry only.
module warp_wait_fifo #(
  parameter int N     = 8,
  parameter int REQ_W = 3,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [IW-1:0]    push_id_i,
  input  logic [REQ_W-1:0] push_reqs_i,
  input  logic             done_i,
  output logic             pop_o,
  output logic [IW-1:0]    head_id_o
);

  logic [IW-1:0]    id_mem  [N];
  logic [REQ_W-1:0] req_mem [N];
  logic [IW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    count_q;
  logic [REQ_W-1:0] served_q;
  logic             credit;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_i) begin
      id_mem[wr_q]  <= push_id_i;
      req_mem[wr_q] <= (push_reqs_i == '0) ? REQ_W'(1) : push_reqs_i;
    end
  end

  assign credit    = done_i && (count_q != '0);
  assign pop_o     = credit && ((served_q + REQ_W'(1)) == req_mem[rd_q]);
  assign head_id_o = id_mem[rd_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      wr_q     <= '0;
      count_q  <= '0;
      served_q <= '0;
    end else begin
      if (credit)
        served_q <= pop_o ? '0 : served_q + REQ_W'(1);
      if (pop_o)
        rd_q <= wrap_inc(rd_q);
      if (push_i)
        wr_q <= wrap_inc(wr_q);
      case ({push_i, pop_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (count_q < CW'(N)));

  a_r8_head_credit_bound: assert property (@(posedge clk) disable iff (rst)
    (count_q != '0) |-> (served_q < req_mem[rd_q]));

endmodule

// File: rtl/warp_prio_sched.sv
module warp_prio_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int MAX_GROUP = 4,
  parameter int REQ_W     = 3,
  localparam int IW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_ready_i,
  input  logic                 stall_valid_i,
  input  logic [IW-1:0]        stall_warp_i,
  input  logic [REQ_W-1:0]     stall_reqs_i,
  input  logic                 mem_done_i,
  input  logic                 prio_set_i,
  input  logic [NUM_WARPS-1:0] prio_mask_i,
  input  logic                 prio_clr_i,
  output logic                 grant_valid_o,
  output logic [IW-1:0]        grant_warp_o
);

  logic [NUM_WARPS-1:0] rdy_q, wt_q, rdy_n, wt_n;
  logic [NUM_WARPS-1:0] prio_w;
  logic [NUM_WARPS-1:0] cand [NUM_CLASSES];
  logic [IW-1:0]        ptr_q [NUM_CLASSES];
  logic [IW-1:0]        pick_idx [NUM_CLASSES];
  logic [NUM_CLASSES-1:0] hit;
  prio_class_e          sel_cls;
  logic                 sel_hit;
  logic [IW-1:0]        sel_idx;
  logic                 stall_acc;
  logic                 pop_w;
  logic [IW-1:0]        head_w;

  warp_prio_group #(.N(NUM_WARPS), .MAX_GROUP(MAX_GROUP)) u_group (
    .clk    (clk),
    .rst    (rst),
    .set_i  (prio_set_i),
    .mask_i (prio_mask_i),
    .clr_i  (prio_clr_i),
    .prio_o (prio_w)
  );

  assign cand[int'(CLS_NORM)] = rdy_q & ~prio_w;
  assign cand[int'(CLS_HIGH)] = rdy_q & prio_w;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_pick
    warp_rr_pick #(.N(NUM_WARPS)) u_pick (
      .req (cand[c]),
      .ptr (ptr_q[c]),
      .hit (hit[c]),
      .idx (pick_idx[c])
    );
  end

  assign sel_cls = hit[int'(CLS_HIGH)] ? CLS_HIGH : CLS_NORM;
  assign sel_hit = |hit;
  assign sel_idx = pick_idx[int'(sel_cls)];

  // Stall wins over a same-cycle ready pulse; waiting warps cannot stall again.
  assign stall_acc = stall_valid_i && !wt_q[stall_warp_i] &&
                     (rdy_q[stall_warp_i] || warp_ready_i[stall_warp_i]);

  warp_wait_fifo #(.N(NUM_WARPS), .REQ_W(REQ_W)) u_wait (
    .clk         (clk),
    .rst         (rst),
    .push_i      (stall_acc),
    .push_id_i   (stall_warp_i),
    .push_reqs_i (stall_reqs_i),
    .done_i      (mem_done_i),
    .pop_o       (pop_w),
    .head_id_o   (head_w)
  );

  always_comb begin
    rdy_n = rdy_q | (warp_ready_i & ~wt_q);
    wt_n  = wt_q;
    if (stall_acc) begin
      rdy_n[stall_warp_i] = 1'b0;
      wt_n[stall_warp_i]  = 1'b1;
    end
    if (pop_w) begin
      rdy_n[head_w] = 1'b1;
      wt_n[head_w]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q         <= '0;
      wt_q          <= '0;
      grant_valid_o <= 1'b0;
      grant_warp_o  <= '0;
      for (int c = 0; c < NUM_CLASSES; c++) ptr_q[c] <= '0;
    end else begin
      rdy_q         <= rdy_n;
      wt_q          <= wt_n;
      grant_valid_o <= sel_hit;
      grant_warp_o  <= sel_idx;
      if (sel_hit)
        ptr_q[int'(sel_cls)] <= (sel_idx == IW'(NUM_WARPS - 1)) ? '0 : sel_idx + 1'b1;
    end
  end

  a_r1_pick_is_ready: assert property (@(posedge clk) disable iff (rst)
    sel_hit |-> rdy_q[sel_idx]);

  a_r1_grant_follows: assert property (@(posedge clk) disable iff (rst)
    (|rdy_q) |=> grant_valid_o);

  a_r4_high_first: assert property (@(posedge clk) disable iff (rst)
    (|(rdy_q & prio_w)) |-> prio_w[sel_idx]);

  a_r7_ready_wait_disjoint: assert property (@(posedge clk) disable iff (rst)
    (rdy_q & wt_q) == '0);

endmodule

// File: tb/warp_prio_sched_bench.sv
module warp_prio_sched_bench;

  localparam int N  = 8;
  localparam int MG = 4;
  localparam int RW = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] warp_ready_i = '0;
  logic         stall_valid_i = 1'b0;
  logic [2:0]   stall_warp_i = '0;
  logic [RW-1:0] stall_reqs_i = '0;
  logic         mem_done_i = 1'b0;
  logic         prio_set_i = 1'b0;
  logic [N-1:0] prio_mask_i = '0;
  logic         prio_clr_i = 1'b0;
  logic         grant_valid_o;
  logic [2:0]   grant_warp_o;

  always #2 clk = ~clk;  // 250 MHz

  warp_prio_sched #(.NUM_WARPS(N), .MAX_GROUP(MG), .REQ_W(RW)) u_warp_prio_sched (
    .clk, .rst, .warp_ready_i, .stall_valid_i, .stall_warp_i, .stall_reqs_i,
    .mem_done_i, .prio_set_i, .prio_mask_i, .prio_clr_i,
    .grant_valid_o, .grant_warp_o
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    finished = 1'b0;
  bit    compare_on = 1'b0;
  string phase = "R9 reset";

  // Behavioural reference model.
  bit [N-1:0] m_rdy, m_wt, m_prio;
  bit         m_lock;
  int         m_ptr [2];
  int         q_id [$];
  int         q_req [$];
  int         m_served;
  bit         e_valid;
  int         e_warp;

  always @(posedge clk) begin
    if (rst) begin
      m_rdy = '0; m_wt = '0; m_prio = '0; m_lock = 0;
      m_ptr[0] = 0; m_ptr[1] = 0; m_served = 0;
      q_id.delete(); q_req.delete();
      e_valid = 0; e_warp = 0;
    end else begin
      bit [N-1:0] hi, cand, nr;
      int cls, w, pw;
      bit acc, popped;
      hi   = m_rdy & m_prio;
      cls  = (hi != 0) ? 1 : 0;
      cand = (hi != 0) ? hi : (m_rdy & ~m_prio);
      e_valid = (m_rdy != 0);
      if (e_valid) begin
        for (int i = 0; i < N; i++) begin
          if (cand[(m_ptr[cls] + i) % N]) begin
            e_warp = (m_ptr[cls] + i) % N;
            break;
          end
        end
        m_ptr[cls] = (e_warp + 1) % N;
      end
      w   = int'(stall_warp_i);
      acc = stall_valid_i && !m_wt[w] && (m_rdy[w] || warp_ready_i[w]);
      popped = 0; pw = 0;
      if (mem_done_i && q_id.size() > 0) begin
        m_served++;
        if (m_served == q_req[0]) begin
          pw = q_id.pop_front();
          void'(q_req.pop_front());
          m_served = 0;
          popped = 1;
        end
      end
      nr = m_rdy | (warp_ready_i & ~m_wt);
      if (acc) begin
        nr[w] = 0; m_wt[w] = 1;
        q_id.push_back(w);
        q_req.push_back((stall_reqs_i == 0) ? 1 : int'(stall_reqs_i));
      end
      if (popped) begin
        nr[pw] = 1; m_wt[pw] = 0;
      end
      m_rdy = nr;
      if (prio_clr_i) begin
        m_prio = '0; m_lock = 0;
      end else if (prio_set_i && !m_lock) begin
        int taken;
        taken = 0; m_prio = '0;
        for (int i = 0; i < N; i++)
          if (prio_mask_i[i] && taken < MG) begin m_prio[i] = 1; taken++; end
        m_lock = 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (compare_on && !rst) begin
      checks++;
      if (grant_valid_o !== e_valid ||
          (e_valid && int'(grant_warp_o) != e_warp)) begin
        fails++;
        $display("FAIL %s: grant valid=%0d warp=%0d, expected valid=%0d warp=%0d",
                 phase, grant_valid_o, grant_warp_o, e_valid, e_warp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic drive(input logic [N-1:0] rdy, input bit sv, input int sw,
                       input int sr, input bit dn, input bit st,
                       input logic [N-1:0] mk, input bit cl);
    @(negedge clk);
    warp_ready_i  = rdy;
    stall_valid_i = sv;
    stall_warp_i  = 3'(sw);
    stall_reqs_i  = RW'(sr);
    mem_done_i    = dn;
    prio_set_i    = st;
    prio_mask_i   = mk;
    prio_clr_i    = cl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, 0, 0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R9: grant_valid=%0d expected 0", grant_valid_o);
    end
    rst = 1'b0;
    compare_on = 1'b1;
    phase = "R7 R1 stall-over-ready";
    drive(8'h01, 1, 0, 1, 0, 0, '0, 0);
    drive('0, 1, 3, 2, 0, 0, '0, 0);
    idle(2);
    phase = "R8 return";
    drive('0, 0, 0, 0, 1, 0, '0, 0);
    idle(2);
    drive('0, 0, 0, 0, 1, 0, '0, 0);
    idle(1);
    phase = "R2 round-robin";
    drive(8'hFF, 0, 0, 0, 0, 0, '0, 0);
    idle(12);
    phase = "R3 clamp";
    drive('0, 0, 0, 0, 0, 1, 8'hFF, 0);
    idle(10);
    phase = "R6 locked";
    drive('0, 0, 0, 0, 0, 1, 8'hF0, 0);
    idle(8);
    phase = "R4 high first";
    drive('0, 1, 1, 3, 0, 0, '0, 0);
    drive('0, 1, 2, 1, 0, 0, '0, 0);
    idle(3);
    drive('0, 0, 0, 0, 1, 0, '0, 0);
    drive('0, 0, 0, 0, 1, 0, '0, 0);
    idle(2);
    drive('0, 0, 0, 0, 1, 0, '0, 0);
    drive('0, 0, 0, 0, 1, 0, '0, 0);
    idle(6);
    phase = "R5 clear";
    drive('0, 0, 0, 0, 0, 1, 8'h0F, 1);
    idle(6);
    drive('0, 0, 0, 0, 0, 1, 8'h30, 0);
    idle(6);
    drive('0, 0, 0, 0, 0, 0, '0, 1);
    idle(6);
    phase = "R1 R7 R8 mixed";
    for (int k = 0; k < 400; k++) begin
      drive(($urandom % 4 == 0) ? N'($urandom) : '0,
            ($urandom % 4 == 0), int'($urandom % N), int'($urandom % 8),
            ($urandom % 3 == 0), ($urandom % 20 == 0), N'($urandom),
            ($urandom % 25 == 0));
    end
    idle(4);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule